// File: doc/BRIEF.md
# Deviation Counter Clear Pulse Generator

This block drives the output that tells a servo drive to zero its position deviation counter. It raises that output when an axis is halted abruptly, or when a homing move finishes. Each of the two causes has its own enable. A halt that slows the axis down first never fires the output.

The active phase is either a timed pulse or a level. The timed pulse has one of seven coded widths between 12 µs and 104 ms. The level stays asserted until a release strobe arrives. After the active phase, a coded off time keeps the block busy so that it cannot fire again, and triggers that arrive while the block is busy are dropped. The output polarity is selectable and takes effect at once.

All durations are counted in 1 µs ticks. The ticks are divided down from the system clock, whose frequency is a parameter. The width code and the off-time code are captured at the moment the block fires.

Top module: `dev_clear_pulse`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and `clrPin` sits at its inactive level (the complement of `cfgActiveHigh`).
- R2: While idle, a cycle with `immStop`=1, `cfgStopEn`=1 and `decStop`=0 starts the active phase, and `busy` is 1 one cycle later. With `cfgStopEn`=0, `immStop` is ignored.
- R3: `decStop` never starts the output. When `immStop` and `decStop` are both 1 in the same cycle, the stop counts as a deceleration stop and nothing fires.
- R4: While idle, `homeDone`=1 with `cfgHomeEn`=1 starts the active phase. With `cfgHomeEn`=0, `homeDone` is ignored.
- R5: `cfgWidthSel` codes 0 through 6 give an active pulse of 12, 102, 409, 1600, 13000, 52000 and 104000 µs ticks respectively.
- R6: `cfgWidthSel`=7 selects level mode. The output stays active until a cycle with `levelRelease`=1, and the active phase ends on the following edge. `levelRelease` has no effect while the block is idle.
- R7: `clrPin` equals the active state when `cfgActiveHigh`=1 and its complement when `cfgActiveHigh`=0. A change of `cfgActiveHigh` takes effect in the same cycle.
- R8: After the active phase, `cfgHoldSel` codes 0, 1, 2 and 3 keep `busy` high with the output inactive for 0, 12, 1600 and 104000 µs ticks respectively. With code 0, the block is idle in the cycle right after the last active cycle.
- R9: Triggers that arrive while `busy` is 1, during either the active phase or the off time, are ignored.
- R10: The width code and the off-time code are captured when the block fires. Later changes to them do not alter the phase that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| immStop | input | 1 | Strobe: axis halted abruptly by a limit or alarm input |
| decStop | input | 1 | Strobe: the halt is a deceleration stop |
| homeDone | input | 1 | Strobe: a homing move has completed |
| levelRelease | input | 1 | Strobe that ends the active phase in level mode |
| cfgStopEn | input | 1 | Enables firing on an abrupt halt |
| cfgHomeEn | input | 1 | Enables firing on homing completion |
| cfgWidthSel | input | 3 | Active-phase width code; 7 selects level mode |
| cfgActiveHigh | input | 1 | Output polarity: 1 = active high, 0 = active low |
| cfgHoldSel | input | 2 | Off-time code |
| clrPin | output | 1 | Deviation counter clear output |
| busy | output | 1 | High from the first active cycle to the end of the off time |

## Verification
Every trigger is sampled on a clock edge, and `busy` together with the active level of `clrPin` appear in the cycle that follows that edge. The bench runs the block with one tick per clock, so a width code of N ticks gives exactly N active cycles, and the off time then adds its own count of cycles before `busy` drops. A level release takes effect one edge after it is seen, while a polarity change shows at the pin in the same cycle. A behavioural model in the bench steps on each rising edge from the same sampled inputs, and the outputs are compared 1 ns after that edge, when all of these delays have settled.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  localparam int unsigned LONGEST_US = 104000;
  localparam int          CNT_W      = $clog2(LONGEST_US + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [2:0] LEVEL_CODE = 3'd7;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PULSE = 2'd1,
    PH_LEVEL = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadWidth;
    logic loadHold;
    logic decrement;
  } dpCmd_t;

  function automatic cnt_t widthUs(input logic [2:0] code);
    case (code)
      3'd0:    return cnt_t'(12);
      3'd1:    return cnt_t'(102);
      3'd2:    return cnt_t'(409);
      3'd3:    return cnt_t'(1600);
      3'd4:    return cnt_t'(13000);
      3'd5:    return cnt_t'(52000);
      3'd6:    return cnt_t'(104000);
      default: return cnt_t'(1);
    endcase
  endfunction

  function automatic cnt_t holdUs(input logic [1:0] code);
    case (code)
      2'd1:    return cnt_t'(12);
      2'd2:    return cnt_t'(1600);
      2'd3:    return cnt_t'(104000);
      default: return cnt_t'(0);
    endcase
  endfunction

endpackage

// File: rtl/dcp_tick.sv
module dcp_tick #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned DIV  = (CLK_HZ >= 2_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int          DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = (divCnt == LAST);

endmodule

// File: rtl/dcp_datapath.sv
module dcp_datapath
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpCmd_t     cmd,
  input  logic [2:0] widthSel,
  input  logic [1:0] holdSel,
  input  logic       activeHigh,
  input  logic       driveActive,
  output logic       cntZero,
  output logic       holdIsZero,
  output logic       pinOut
);
  cnt_t       cnt;
  logic [1:0] holdSelQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      holdSelQ <= '0;
    end else begin
      if (cmd.capture) holdSelQ <= holdSel;
      if (cmd.loadWidth) begin
        cnt <= widthUs(widthSel) - 1'b1;
      end else if (cmd.loadHold) begin
        cnt <= holdUs(holdSelQ) - 1'b1;
      end else if (cmd.decrement) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cntZero    = (cnt == '0);
  assign holdIsZero = (holdSelQ == 2'd0);
  assign pinOut     = activeHigh ? driveActive : ~driveActive;

endmodule

// File: rtl/dcp_ctrl.sv
module dcp_ctrl
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       immStop,
  input  logic       decStop,
  input  logic       homeDone,
  input  logic       relPulse,
  input  logic       stopEn,
  input  logic       homeEn,
  input  logic [2:0] widthSel,
  input  logic       cntZero,
  input  logic       holdIsZero,
  output dpCmd_t     cmd,
  output logic       driveActive,
  output logic       busyOut,
  output logic       inLevel
);
  phase_e phase, phaseNxt;
  logic   fire;

  // a deceleration stop in the same cycle overrules the abrupt halt
  assign fire = (immStop & stopEn & ~decStop) | (homeDone & homeEn);

  always_comb begin
    cmd      = '0;
    phaseNxt = phase;
    case (phase)
      PH_IDLE: begin
        if (fire) begin
          cmd.capture = 1'b1;
          if (widthSel == LEVEL_CODE) begin
            phaseNxt = PH_LEVEL;
          end else begin
            cmd.loadWidth = 1'b1;
            phaseNxt      = PH_PULSE;
          end
        end
      end
      PH_PULSE: begin
        if (tick) begin
          if (!cntZero) begin
            cmd.decrement = 1'b1;
          end else if (holdIsZero) begin
            phaseNxt = PH_IDLE;
          end else begin
            cmd.loadHold = 1'b1;
            phaseNxt     = PH_HOLD;
          end
        end
      end
      PH_LEVEL: begin
        if (relPulse) begin
          if (holdIsZero) begin
            phaseNxt = PH_IDLE;
          end else begin
            cmd.loadHold = 1'b1;
            phaseNxt     = PH_HOLD;
          end
        end
      end
      PH_HOLD: begin
        if (tick) begin
          if (cntZero) phaseNxt = PH_IDLE;
          else         cmd.decrement = 1'b1;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNxt;
  end

  assign driveActive = (phase == PH_PULSE) || (phase == PH_LEVEL);
  assign busyOut     = (phase != PH_IDLE);
  assign inLevel     = (phase == PH_LEVEL);

endmodule

// File: rtl/dev_clear_pulse.sv
module dev_clear_pulse
  import dcp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       immStop,
  input  logic       decStop,
  input  logic       homeDone,
  input  logic       levelRelease,
  input  logic       cfgStopEn,
  input  logic       cfgHomeEn,
  input  logic [2:0] cfgWidthSel,
  input  logic       cfgActiveHigh,
  input  logic [1:0] cfgHoldSel,
  output logic       clrPin,
  output logic       busy
);
  logic   tick;
  dpCmd_t cmd;
  logic   cntZero, holdIsZero, driveActive, levelPhase;

  dcp_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  dcp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick(tick),
    .immStop(immStop), .decStop(decStop), .homeDone(homeDone),
    .relPulse(levelRelease), .stopEn(cfgStopEn), .homeEn(cfgHomeEn),
    .widthSel(cfgWidthSel), .cntZero(cntZero), .holdIsZero(holdIsZero),
    .cmd(cmd), .driveActive(driveActive), .busyOut(busy), .inLevel(levelPhase)
  );

  dcp_datapath u_dp (
    .clk(clk), .rst(rst), .cmd(cmd),
    .widthSel(cfgWidthSel), .holdSel(cfgHoldSel),
    .activeHigh(cfgActiveHigh), .driveActive(driveActive),
    .cntZero(cntZero), .holdIsZero(holdIsZero), .pinOut(clrPin)
  );

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker (
  input logic clk,
  input logic rst,
  input logic immStop,
  input logic decStop,
  input logic homeDone,
  input logic levelRelease,
  input logic cfgStopEn,
  input logic cfgHomeEn,
  input logic cfgActiveHigh,
  input logic clrPin,
  input logic busy,
  input logic levelPhase
);

  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past((immStop && cfgStopEn && !decStop) || (homeDone && cfgHomeEn))); // R2

  AST_DECEL_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && decStop && !(homeDone && cfgHomeEn)) |=> !busy); // R3

  AST_HOME_GATED: assert property (@(posedge clk) disable iff (rst)
    (!busy && homeDone && !cfgHomeEn && !(immStop && cfgStopEn && !decStop)) |=> !busy); // R4

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (levelPhase && !levelRelease) |=> levelPhase); // R6

  AST_IDLE_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (clrPin == !cfgActiveHigh)); // R7

  AST_ACTIVE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (clrPin == cfgActiveHigh) |-> busy); // R8

endmodule

bind dev_clear_pulse dcp_checker u_chk (
  .clk(clk), .rst(rst), .immStop(immStop), .decStop(decStop),
  .homeDone(homeDone), .levelRelease(levelRelease), .cfgStopEn(cfgStopEn),
  .cfgHomeEn(cfgHomeEn), .cfgActiveHigh(cfgActiveHigh), .clrPin(clrPin),
  .busy(busy), .levelPhase(levelPhase)
);

// File: tb/tb_dev_clear_pulse.sv
`timescale 1ns/1ps
module tb_dev_clear_pulse;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic immStop = 0, decStop = 0, homeDone = 0, levelRelease = 0;
  logic cfgStopEn = 0, cfgHomeEn = 0, cfgActiveHigh = 1;
  logic [2:0] cfgWidthSel = 3'd0;
  logic [1:0] cfgHoldSel = 2'd0;
  logic clrPin, busy;

  always #2 clk = ~clk;

  dev_clear_pulse #(.CLK_HZ(1_000_000)) dut (
    .clk(clk), .rst(rst), .immStop(immStop), .decStop(decStop),
    .homeDone(homeDone), .levelRelease(levelRelease), .cfgStopEn(cfgStopEn),
    .cfgHomeEn(cfgHomeEn), .cfgWidthSel(cfgWidthSel), .cfgActiveHigh(cfgActiveHigh),
    .cfgHoldSel(cfgHoldSel), .clrPin(clrPin), .busy(busy)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference: 0 idle, 1 timed, 2 level, 3 off time
  int mPhase = 0, mRemain = 0, mHold = 0;

  function automatic int wUs(int c);
    case (c)
      0: return 12;     1: return 102;   2: return 409;   3: return 1600;
      4: return 13000;  5: return 52000; default: return 104000;
    endcase
  endfunction

  function automatic int hUs(int c);
    case (c)
      1: return 12; 2: return 1600; 3: return 104000; default: return 0;
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic endActive();
    if (mHold == 0) mPhase = 0;
    else begin mPhase = 3; mRemain = mHold; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mPhase = 0; mRemain = 0; mHold = 0;
    end else begin
      case (mPhase)
        0: if ((immStop && cfgStopEn && !decStop) || (homeDone && cfgHomeEn)) begin
             mHold = hUs(int'(cfgHoldSel));
             if (cfgWidthSel == 3'd7) mPhase = 2;
             else begin mPhase = 1; mRemain = wUs(int'(cfgWidthSel)); end
           end
        1: begin mRemain--; if (mRemain == 0) endActive(); end
        2: if (levelRelease) endActive();
        default: begin mRemain--; if (mRemain == 0) mPhase = 0; end
      endcase
    end
    #1;
    if (!finished) begin
      check(curReq, "busy", busy, mPhase != 0);
      check(curReq, "clrPin", clrPin,
            cfgActiveHigh ? (mPhase == 1 || mPhase == 2) : !(mPhase == 1 || mPhase == 2));
    end
    if (cycles >= 195000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 immStop, 1 decStop, 2 homeDone, 3 release, 4 imm+dec
  task automatic strobe(int which);
    case (which)
      0: immStop = 1;
      1: decStop = 1;
      2: homeDone = 1;
      3: levelRelease = 1;
      default: begin immStop = 1; decStop = 1; end
    endcase
    @(negedge clk);
    immStop = 0; decStop = 0; homeDone = 0; levelRelease = 0;
  endtask

  task automatic doReset();
    rst = 1; waitCyc(2); rst = 0;
  endtask

  initial begin
    waitCyc(3);
    check("R1", "reset busy", busy, 1'b0);
    check("R1", "reset pin", clrPin, 1'b0);
    rst = 0;
    waitCyc(2);

    curReq = "R2"; cfgStopEn = 1;
    strobe(0);
    check("R2", "busy after stop", busy, 1'b1);
    waitCyc(20);
    check("R2", "done after 12", busy, 1'b0);
    cfgStopEn = 0;
    strobe(0);
    check("R2", "disabled stop", busy, 1'b0);
    waitCyc(3);

    curReq = "R3"; cfgStopEn = 1;
    strobe(4);
    check("R3", "imm+dec", busy, 1'b0);
    strobe(1);
    check("R3", "dec alone", busy, 1'b0);
    waitCyc(3);

    curReq = "R4"; cfgStopEn = 0; cfgHomeEn = 1;
    strobe(2);
    check("R4", "home fires", busy, 1'b1);
    waitCyc(20);
    cfgHomeEn = 0;
    strobe(2);
    check("R4", "home disabled", busy, 1'b0);
    waitCyc(3);

    curReq = "R7"; cfgHomeEn = 1; cfgActiveHigh = 0;
    strobe(2);
    check("R7", "active low pin", clrPin, 1'b0);
    waitCyc(4);
    cfgActiveHigh = 1;
    #0.5;
    check("R7", "live polarity", clrPin, 1'b1);
    waitCyc(20);

    curReq = "R5";
    for (int c = 1; c < 6; c++) begin
      cfgWidthSel = 3'(c);
      strobe(2);
      waitCyc(wUs(c) - 2);
      check("R5", "still active", clrPin, 1'b1);
      waitCyc(4);
      check("R5", "ended", busy, 1'b0);
    end
    cfgWidthSel = 3'd6;
    strobe(2);
    waitCyc(300);
    check("R5", "longest active", clrPin, 1'b1);
    doReset();
    check("R1", "reset mid-pulse", busy, 1'b0);
    waitCyc(2);

    curReq = "R6"; cfgWidthSel = 3'd7; cfgHoldSel = 2'd1;
    strobe(3);
    check("R6", "release idle", busy, 1'b0);
    strobe(2);
    waitCyc(40);
    check("R6", "level held", clrPin, 1'b1);
    strobe(3);
    check("R6", "released", clrPin, 1'b0);
    check("R8", "off time busy", busy, 1'b1);
    waitCyc(15);
    check("R8", "off 12 done", busy, 1'b0);

    curReq = "R8"; cfgWidthSel = 3'd0; cfgHoldSel = 2'd2;
    strobe(2);
    waitCyc(12 + 1500);
    check("R8", "in off time", busy, 1'b1);
    waitCyc(120);
    check("R8", "off 1600 done", busy, 1'b0);
    cfgHoldSel = 2'd3;
    strobe(2);
    waitCyc(500);
    check("R8", "long off", busy, 1'b1);
    doReset();
    cfgHoldSel = 2'd0;
    strobe(2);
    waitCyc(12);
    strobe(2);
    check("R8", "zero off refire", busy, 1'b1);
    waitCyc(20);

    curReq = "R9"; cfgHoldSel = 2'd1; cfgStopEn = 1;
    strobe(2);
    waitCyc(5);
    strobe(0);
    waitCyc(10);
    strobe(2);
    check("R9", "off time pin", clrPin, 1'b0);
    waitCyc(20);
    check("R9", "no retrigger", busy, 1'b0);

    curReq = "R10"; cfgWidthSel = 3'd1; cfgHoldSel = 2'd0;
    strobe(2);
    cfgWidthSel = 3'd0; cfgHoldSel = 2'd3;
    waitCyc(50);
    check("R10", "width kept", clrPin, 1'b1);
    waitCyc(60);
    check("R10", "hold kept", busy, 1'b0);
    waitCyc(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule